// File: doc/BRIEF.md
# Paged Qubit Command Decoder

This block sits on the instruction path of a qubit control pipeline. It takes 64-bit instruction words one at a time over a valid/ready handshake. Each word is split into a command class, a 12-bit opcode, an argument and up to two absolute qubit addresses. The opcode lives in the most significant bits, and the first check made on it decides whether the word is a gate or a control command. Gate words name their qubits with 10-bit indices that are relative to a page. The decoder keeps one page base for each of the two qubit slots, adds the matching base to each relative index, and passes the resulting absolute addresses downstream.

The page bases are session state. Dedicated control words load them, and they keep their value until they are reloaded, until a new session starts, or until reset. A word whose opcode is not in the decode table is dropped and a one-cycle error pulse is raised. A gate whose address does not fit the output width is also dropped, with a separate pulse. Neither case stalls the input stream.

Top module: `qcd_decoder`

## Requirements
- R1: The opcode is in bits [63:52]. Control words carry a 16-bit argument in [51:36], which is emitted zero-extended to 32 bits. Gate words carry a 32-bit argument in [51:20]. Bits outside these fields do not change any output.
- R2: The legal control opcodes are 0x001 (start session), 0x002 (load page 0), 0x003 (load page 1), 0x004 (end session) and 0x005 (section mark). Each is emitted with class 0 and both qubit outputs at zero.
- R3: When opcode bit 11 is 0, codes 0x100 through 0x100+NUM_G1-1 are one-qubit gates. They are emitted with class 1, q0 = page0 + word[19:10], and q1 = 0.
- R4: When opcode bit 11 is 1, codes 0x800 through 0x800+NUM_G2-1 are two-qubit gates. They are emitted with class 2, q0 = page0 + word[19:10], and q1 = page1 + word[9:0].
- R5: Load page 0 and load page 1 copy word[35:0] into their own base. That base is then used by every later gate until it is loaded again.
- R6: Reset clears both bases to zero, and so does the start session command.
- R7: If a base-plus-index sum does not fit in ABS_W bits, the word is not emitted and err_range pulses for one cycle. For a two-qubit gate, either slot overflowing is enough.
- R8: Any other opcode produces a one-cycle err_opcode pulse. The word is dropped and does not stall the next word.
- R9: A word accepted at one clock edge produces its output or its error pulse after exactly that edge. While out_ready is high, one word is accepted every cycle.
- R10: While out_valid is high and out_ready is low, in_ready is low and every output field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Decoder can take a word |
| in_word | input | 64 | Instruction word |
| out_valid | output | 1 | Decoded command valid |
| out_ready | input | 1 | Downstream takes the command |
| out_cls | output | 2 | Class: 0 control, 1 one-qubit, 2 two-qubit |
| out_opc | output | 12 | Opcode |
| out_arg | output | 32 | Argument |
| out_q0 | output | ABS_W | Absolute address of qubit slot 0 |
| out_q1 | output | ABS_W | Absolute address of qubit slot 1 |
| err_opcode | output | 1 | Unknown opcode pulse |
| err_range | output | 1 | Address overflow pulse |

## Verification
The bench builds the decoder with ABS_W = 36, NUM_G1 = 32 and NUM_G2 = 8. At the default output width of 46 bits, no 36-bit base plus a 10-bit index can overflow. Narrowing the output to 36 bits makes the overflow drop reachable, both for a base near the top of its range and for each of the two slots separately. The small gate counts place the first unknown code just above each gate range, so the edges of the decode table are exercised next to legal neighbours.

// File: rtl/qcd_pkg.sv
package qcd_pkg;

  localparam int WORD_W    = 64;
  localparam int OPC_W     = 12;
  localparam int CARG_W    = 16;
  localparam int GARG_W    = 32;
  localparam int REL_W     = 10;
  localparam int BASE_W    = 36;
  localparam int OPC_LSB   = WORD_W - OPC_W;
  localparam int CARG_LSB  = OPC_LSB - CARG_W;
  localparam int GARG_LSB  = OPC_LSB - GARG_W;
  localparam int REL0_LSB  = REL_W;
  localparam int REL1_LSB  = 0;

  typedef enum logic [1:0] {
    CLS_CTRL  = 2'd0,
    CLS_GATE1 = 2'd1,
    CLS_GATE2 = 2'd2
  } qcd_cls_e;

  localparam logic [OPC_W-1:0] OPC_SESSION = 12'h001;
  localparam logic [OPC_W-1:0] OPC_PAGE0   = 12'h002;
  localparam logic [OPC_W-1:0] OPC_PAGE1   = 12'h003;
  localparam logic [OPC_W-1:0] OPC_CLOSE   = 12'h004;
  localparam logic [OPC_W-1:0] OPC_SECTION = 12'h005;
  localparam logic [OPC_W-1:0] G1_FIRST    = 12'h100;
  localparam logic [OPC_W-1:0] G2_FIRST    = 12'h800;

endpackage

// File: rtl/qcd_opc_lut.sv
module qcd_opc_lut
  import qcd_pkg::*;
#(
  parameter int NUM_G1 = 32,
  parameter int NUM_G2 = 8
) (
  input  logic [OPC_W-1:0] opc_i,
  output logic             legal_o,
  output qcd_cls_e         cls_o,
  output logic             ld_page0_o,
  output logic             ld_page1_o,
  output logic             clr_pages_o
);

  localparam int IDX_W = OPC_W - 1;

  logic [IDX_W-1:0] g2_idx;
  logic [OPC_W-1:0] g1_off;

  always_comb begin
    g2_idx      = opc_i[IDX_W-1:0];
    g1_off      = opc_i - G1_FIRST;
    legal_o     = 1'b0;
    cls_o       = CLS_CTRL;
    ld_page0_o  = 1'b0;
    ld_page1_o  = 1'b0;
    clr_pages_o = 1'b0;
    if (opc_i[OPC_W-1]) begin
      cls_o   = CLS_GATE2;
      legal_o = (32'(g2_idx) < NUM_G2);
    end else if (opc_i >= G1_FIRST) begin
      cls_o   = CLS_GATE1;
      legal_o = (32'(g1_off) < NUM_G1);
    end else begin
      cls_o = CLS_CTRL;
      unique case (opc_i)
        OPC_SESSION: begin legal_o = 1'b1; clr_pages_o = 1'b1; end
        OPC_PAGE0:   begin legal_o = 1'b1; ld_page0_o  = 1'b1; end
        OPC_PAGE1:   begin legal_o = 1'b1; ld_page1_o  = 1'b1; end
        OPC_CLOSE:   legal_o = 1'b1;
        OPC_SECTION: legal_o = 1'b1;
        default:     legal_o = 1'b0;
      endcase
    end
  end

  always_comb begin
    if (ld_page0_o || ld_page1_o || clr_pages_o)
      assert (legal_o && cls_o == CLS_CTRL && $onehot({ld_page0_o, ld_page1_o, clr_pages_o}))
        else $error("assert_page_ctrl_R5");
  end

endmodule

// File: rtl/qcd_page_regs.sv
module qcd_page_regs
  import qcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic              ld0_i,
  input  logic              ld1_i,
  input  logic [BASE_W-1:0] data_i,
  output logic [BASE_W-1:0] base0_o,
  output logic [BASE_W-1:0] base1_o
);

  logic [BASE_W-1:0] base0_q, base0_d;
  logic [BASE_W-1:0] base1_q, base1_d;

  always_comb begin
    base0_d = base0_q;
    base1_d = base1_q;
    if (en_i) begin
      if (clr_i) begin
        base0_d = '0;
        base1_d = '0;
      end else begin
        if (ld0_i) base0_d = data_i;
        if (ld1_i) base1_d = data_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base0_q <= '0;
      base1_q <= '0;
    end else if (en_i) begin
      base0_q <= base0_d;
      base1_q <= base1_d;
    end
  end

  assign base0_o = base0_q;
  assign base1_o = base1_q;

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && clr_i |=> base0_q == '0 && base1_q == '0);

  assert_persist_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(base0_q) && $stable(base1_q));

endmodule

// File: rtl/qcd_addr_add.sv
module qcd_addr_add
  import qcd_pkg::*;
#(
  parameter int ABS_W = 46
) (
  input  logic [BASE_W-1:0] base_i,
  input  logic [REL_W-1:0]  rel_i,
  output logic [ABS_W-1:0]  abs_o,
  output logic              ovf_o
);

  localparam int SUM_W = ((BASE_W > REL_W) ? BASE_W : REL_W) + 1;
  localparam int EXT_W = (SUM_W > ABS_W) ? SUM_W : ABS_W;

  logic [EXT_W-1:0] sum;

  always_comb begin
    sum   = EXT_W'(base_i) + EXT_W'(rel_i);
    abs_o = sum[ABS_W-1:0];
    ovf_o = (sum >> ABS_W) != '0;
  end

endmodule

// File: rtl/qcd_decoder.sv
module qcd_decoder
  import qcd_pkg::*;
#(
  parameter int NUM_G1 = 32,
  parameter int NUM_G2 = 8,
  parameter int ABS_W  = 46
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [63:0]       in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_cls,
  output logic [11:0]       out_opc,
  output logic [31:0]       out_arg,
  output logic [ABS_W-1:0]  out_q0,
  output logic [ABS_W-1:0]  out_q1,
  output logic              err_opcode,
  output logic              err_range
);

  localparam int NSLOT = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  // field split
  logic [OPC_W-1:0]  opc;
  logic [CARG_W-1:0] carg;
  logic [GARG_W-1:0] garg;
  logic [BASE_W-1:0] base_fld;
  logic [REL_W-1:0]  rel [NSLOT];

  assign opc      = in_word[OPC_LSB +: OPC_W];
  assign carg     = in_word[CARG_LSB +: CARG_W];
  assign garg     = in_word[GARG_LSB +: GARG_W];
  assign base_fld = in_word[BASE_W-1:0];
  assign rel[0]   = in_word[REL0_LSB +: REL_W];
  assign rel[1]   = in_word[REL1_LSB +: REL_W];

  // lookup
  logic     legal, ld0, ld1, clr;
  qcd_cls_e cls;

  qcd_opc_lut #(.NUM_G1(NUM_G1), .NUM_G2(NUM_G2)) u_lut (
    .opc_i       (opc),
    .legal_o     (legal),
    .cls_o       (cls),
    .ld_page0_o  (ld0),
    .ld_page1_o  (ld1),
    .clr_pages_o (clr)
  );

  // handshake
  logic out_valid_q, out_valid_d;
  logic acc;

  assign in_ready = !out_valid_q || out_ready;
  assign acc      = in_valid && in_ready;

  // page bases
  logic [BASE_W-1:0] base [NSLOT];

  qcd_page_regs u_pages (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .en_i    (acc && legal),
    .clr_i   (clr),
    .ld0_i   (ld0),
    .ld1_i   (ld1),
    .data_i  (base_fld),
    .base0_o (base[0]),
    .base1_o (base[1])
  );

  // per-slot address adders
  logic [ABS_W-1:0] abs_addr [NSLOT];
  logic             ovf      [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    qcd_addr_add #(.ABS_W(ABS_W)) u_add (
      .base_i (base[g]),
      .rel_i  (rel[g]),
      .abs_o  (abs_addr[g]),
      .ovf_o  (ovf[g])
    );
  end

  // next-state
  logic              ovf_any, emit;
  logic [1:0]        cls_d;
  logic [31:0]       arg_d;
  logic [ABS_W-1:0]  q0_d, q1_d;
  logic              err_opc_d, err_rng_d;

  always_comb begin
    ovf_any = 1'b0;
    cls_d   = cls;
    arg_d   = 32'(carg);
    q0_d    = '0;
    q1_d    = '0;
    unique case (cls)
      CLS_GATE1: begin
        ovf_any = ovf[0];
        arg_d   = garg;
        q0_d    = abs_addr[0];
      end
      CLS_GATE2: begin
        ovf_any = ovf[0] || ovf[1];
        arg_d   = garg;
        q0_d    = abs_addr[0];
        q1_d    = abs_addr[1];
      end
      default: ;
    endcase
    emit        = legal && !ovf_any;
    out_valid_d = acc ? emit : (out_valid_q && !out_ready);
    err_opc_d   = acc && !legal;
    err_rng_d   = acc && legal && ovf_any;
  end

  // registers
  logic [1:0]       cls_q;
  logic [OPC_W-1:0] opc_q;
  logic [31:0]      arg_q;
  logic [ABS_W-1:0] q0_q, q1_q;
  logic             err_opc_q, err_rng_q;
  logic             load_out;

  assign load_out = acc && emit;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      out_valid_q <= 1'b0;
      err_opc_q   <= 1'b0;
      err_rng_q   <= 1'b0;
    end else begin
      out_valid_q <= out_valid_d;
      err_opc_q   <= err_opc_d;
      err_rng_q   <= err_rng_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cls_q <= '0;
      opc_q <= '0;
      arg_q <= '0;
      q0_q  <= '0;
      q1_q  <= '0;
    end else if (load_out) begin
      cls_q <= cls_d;
      opc_q <= opc;
      arg_q <= arg_d;
      q0_q  <= q0_d;
      q1_q  <= q1_d;
    end
  end

  assign out_valid  = out_valid_q;
  assign out_cls    = cls_q;
  assign out_opc    = opc_q;
  assign out_arg    = arg_q;
  assign out_q0     = q0_q;
  assign out_q1     = q1_q;
  assign err_opcode = err_opc_q;
  assign err_range  = err_rng_q;

  // checks
  assert_opc_drop_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    err_opcode |-> !out_valid);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    err_range |-> !out_valid);

  assert_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({err_opcode, err_range, out_valid}));

  assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    in_valid && in_ready |=> out_valid || err_opcode || err_range);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_valid && !out_ready |=> out_valid && $stable(out_cls) && $stable(out_opc)
      && $stable(out_arg) && $stable(out_q0) && $stable(out_q1));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_valid && !out_ready |-> !in_ready);

  assert_g1_q1_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_valid && out_cls == 2'd1 |-> out_q1 == '0 && !out_opc[OPC_W-1]);

  assert_ctrl_q_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_valid && out_cls == 2'd0 |-> out_q0 == '0 && out_q1 == '0 && out_arg[31:16] == '0);

endmodule

// File: tb/qcd_decoder_tb.sv
module qcd_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_G1 = 32;
  localparam int NUM_G2 = 8;
  localparam int ABS_W  = 36;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic              in_ready;
  logic [63:0]       in_word;
  logic              out_valid;
  logic              out_ready;
  logic [1:0]        out_cls;
  logic [11:0]       out_opc;
  logic [31:0]       out_arg;
  logic [ABS_W-1:0]  out_q0, out_q1;
  logic              err_opcode, err_range;

  always #(CLK_PERIOD/2) clk = ~clk;

  qcd_decoder #(.NUM_G1(NUM_G1), .NUM_G2(NUM_G2), .ABS_W(ABS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_cls(out_cls), .out_opc(out_opc), .out_arg(out_arg),
    .out_q0(out_q0), .out_q1(out_q1), .err_opcode(err_opcode), .err_range(err_range)
  );

  typedef struct packed {
    logic [1:0]  kind;   // 0 emit, 1 bad opcode, 2 range
    logic [1:0]  cls;
    logic [11:0] opc;
    logic [31:0] arg;
    logic [63:0] q0;
    logic [63:0] q1;
  } exp_t;

  exp_t        sb[$];
  int          n_checks = 0;
  int          n_fail   = 0;
  logic [63:0] m_b0 = '0, m_b1 = '0;
  logic        stall_en = 1'b0;
  logic        no_wait  = 1'b0;
  logic        mon_en   = 1'b0;
  logic [31:0] seed = 32'h1ACE_B00C;
  logic [63:0] amask = (64'd1 << ABS_W) - 64'd1;

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [63:0] w);
    exp_t e;
    logic [11:0] op;
    logic [63:0] s0, s1;
    op = w[63:52];
    e = '0;
    e.opc = op;
    s0 = m_b0 + 64'(w[19:10]);
    s1 = m_b1 + 64'(w[9:0]);
    if (op[11]) begin
      if (int'(op[10:0]) < NUM_G2) begin
        if ((s0 >> ABS_W) != 0 || (s1 >> ABS_W) != 0) e.kind = 2'd2;
        else begin e.cls = 2'd2; e.arg = w[51:20]; e.q0 = s0; e.q1 = s1; end
      end else e.kind = 2'd1;
    end else if (op >= 12'h100) begin
      if (int'(op) - 256 < NUM_G1) begin
        if ((s0 >> ABS_W) != 0) e.kind = 2'd2;
        else begin e.cls = 2'd1; e.arg = w[51:20]; e.q0 = s0; end
      end else e.kind = 2'd1;
    end else if (op >= 12'h001 && op <= 12'h005) begin
      e.cls = 2'd0;
      e.arg = 32'(w[51:36]);
      if (op == 12'h001) begin m_b0 = '0; m_b1 = '0; end
      if (op == 12'h002) m_b0 = 64'(w[35:0]);
      if (op == 12'h003) m_b1 = 64'(w[35:0]);
    end else e.kind = 2'd1;
    return e;
  endfunction

  task automatic send(input logic [63:0] w);
    int waits;
    sb.push_back(model(w));
    in_valid = 1'b1;
    in_word  = w;
    waits = 0;
    forever begin
      @(negedge clk);
      if (in_ready) break;
      waits++;
    end
    @(posedge clk);
    #1;
    if (no_wait) chk(waits == 0, "R9 throughput", 64'(waits), 64'd0);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [63:0] mk(input logic [11:0] op, input logic [31:0] arg,
                                     input logic [9:0] r0, input logic [9:0] r1);
    return {op, arg, r0, r1};
  endfunction

  function automatic logic [63:0] mkpage(input logic [11:0] op, input logic [15:0] arg,
                                         input logic [35:0] b);
    return {op, arg, b};
  endfunction

  // ready generator
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      seed = nxt(seed);
      out_ready = stall_en ? seed[7] : 1'b1;
    end
  end

  // scoreboard monitor
  logic        prev_stall = 1'b0;
  logic [1:0]  p_cls;
  logic [11:0] p_opc;
  logic [31:0] p_arg;
  logic [ABS_W-1:0] p_q0, p_q1;

  initial begin
    forever begin
      @(negedge clk);
      if (mon_en) begin
        if (prev_stall)
          chk(out_valid && out_cls == p_cls && out_opc == p_opc && out_arg == p_arg
              && out_q0 == p_q0 && out_q1 == p_q1, "R10 hold",
              {out_opc, out_arg, 20'(out_q0)}, {p_opc, p_arg, 20'(p_q0)});
        if (out_valid && out_ready) begin
          if (sb.size() == 0) chk(1'b0, "R9 unexpected output", 64'(out_opc), 64'd0);
          else begin
            exp_t e;
            e = sb.pop_front();
            chk(e.kind == 2'd0, "R7/R8 should have been dropped", 64'(out_opc), 64'(e.kind));
            chk(out_cls == e.cls && out_opc == e.opc && out_arg == e.arg,
                "R1/R2/R3/R4 class/opcode/arg", {out_cls, out_opc, out_arg}, {e.cls, e.opc, e.arg});
            chk(64'(out_q0) == (e.q0 & amask) && 64'(out_q1) == (e.q1 & amask),
                "R3/R4/R5/R6 qubit address", {28'd0, out_q0}, e.q0);
          end
        end
        if (err_opcode || err_range) begin
          if (sb.size() == 0) chk(1'b0, "R8 unexpected error pulse", {err_opcode, err_range}, 64'd0);
          else begin
            exp_t e;
            e = sb.pop_front();
            chk(e.kind == (err_opcode ? 2'd1 : 2'd2), "R7/R8 error kind",
                64'({err_opcode, err_range}), 64'(e.kind));
          end
        end
        prev_stall = out_valid && !out_ready;
        p_cls = out_cls; p_opc = out_opc; p_arg = out_arg; p_q0 = out_q0; p_q1 = out_q1;
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    in_valid = 1'b0;
    in_word  = '0;
    rst_n    = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // reset state
    chk(out_valid == 1'b0, "R6 reset out_valid", 64'(out_valid), 64'd0);
    chk(!err_opcode && !err_range, "R8 reset errors", {err_opcode, err_range}, 64'd0);
    chk(in_ready == 1'b1, "R9 reset in_ready", 64'(in_ready), 64'd1);
    mon_en = 1'b1;

    // R6: bases zero after reset; R9 single-cycle latency
    send(mk(12'h100, 32'hDEAD_BEEF, 10'd5, 10'd999));
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b1, "R9 latency one edge", 64'(out_valid), 64'd1);
    idle(2);

    // R5 page loads, R1 ignored bits in control words
    no_wait = 1'b1;
    send(mkpage(12'h002, 16'h00AA, 36'h1_2345_6789));
    send(mkpage(12'h003, 16'h0055, 36'h0_000A_BCDE));
    send(mk(12'h105, 32'h0102_0304, 10'd1023, 10'd7));
    send(mk(12'h800, 32'hCAFE_F00D, 10'd3, 10'd1023));
    send(mk(12'h807, 32'h0000_0001, 10'd0, 10'd0));
    send(mk(12'h004, 32'hFFFF_FFFF, 10'h3FF, 10'h3FF));
    send(mk(12'h005, 32'h1234_5678, 10'h155, 10'h2AA));
    send(mk(12'h11F, 32'h7, 10'd9, 10'd9));
    // R8 unknown opcodes back to back, no stall
    send(mk(12'h000, 32'h1, 10'd1, 10'd1));
    send(mk(12'h006, 32'h1, 10'd1, 10'd1));
    send(mk(12'h120, 32'h1, 10'd1, 10'd1));
    send(mk(12'h808, 32'h1, 10'd1, 10'd1));
    send(mk(12'h7FF, 32'h1, 10'd1, 10'd1));
    send(mk(12'h101, 32'h2, 10'd2, 10'd2));
    // R6 start session clears bases
    send(mk(12'h001, 32'hABCD_0000, 10'd11, 10'd12));
    send(mk(12'h801, 32'h3, 10'd11, 10'd12));
    // R7 overflow per slot
    send(mkpage(12'h002, 16'h0, 36'hF_FFFF_FFFF));
    send(mk(12'h102, 32'h4, 10'd1, 10'd0));
    send(mk(12'h102, 32'h5, 10'd0, 10'd0));
    send(mkpage(12'h002, 16'h0, 36'h0_0000_0010));
    send(mkpage(12'h003, 16'h0, 36'hF_FFFF_FFFC));
    send(mk(12'h802, 32'h6, 10'd0, 10'd3));
    send(mk(12'h802, 32'h7, 10'd0, 10'd4));
    no_wait = 1'b0;
    idle(4);

    // R10 random traffic with backpressure
    stall_en = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [63:0] w;
      logic [2:0]  k;
      seed = nxt(seed);
      w[63:32] = seed;
      seed = nxt(seed);
      w[31:0] = seed;
      k = w[2:0] ^ w[40:38];
      case (k)
        3'd0, 3'd1: w[63:52] = 12'(1 + (w[45:43] % 5));
        3'd2, 3'd3: w[63:52] = 12'h100 + 12'(w[47:43]);
        3'd4, 3'd5: w[63:52] = 12'h800 + 12'(w[45:43]);
        3'd6:       w[63:52] = w[63:52] | 12'h0C0;
        default: begin
          w[63:52] = w[41] ? 12'h002 : 12'h003;
          w[35:8]  = '1;
        end
      endcase
      if (w[63:52] == 12'h001 && w[50]) w[63:52] = 12'h004;
      send(w);
    end
    stall_en = 1'b0;
    idle(10);
    chk(sb.size() == 0, "R9 all words resolved", 64'(sb.size()), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule